// File: doc/BRIEF.md
# RTS/CTS Handshake Controller

This block drives the clear-to-send output of a synchronous data service unit in answer to the request-to-send input from the attached terminal. When a request is raised, clear-to-send follows after a turnaround delay. That delay depends on the line rate and is optionally doubled. Delays are measured in strobes of a 0.1 ms timing tick that the surrounding chip supplies.

The configuration word holds the rate code, the doubling option, a force-on option and a circuit-assurance option. The block samples this word only on the first clock after reset and on a reload request. Between those events, changes on the configuration pins have no effect. The latched word is brought out so that it can be observed.

With circuit assurance enabled, the receive line signal detector also gates clear-to-send. With the force option set, clear-to-send no longer depends on the request.

Top module: `cts_handshake_ctrl`

## Requirements
- R1: The configuration pins are captured on the first rising clock edge after reset is released, and on every edge that samples `reload_req_i` high. After the capture, `cfg_valid_o` is 1 and the `cfg_*_o` outputs show the captured values.
- R2: `cts_o` is 0 while reset is active and while `cfg_valid_o` is 0. It is also 0 in the cycle after an edge that samples `reload_req_i` high.
- R3: The latched rate code, read as an unsigned value, gives the base delay in ticks. The codes and their line rates are: 0 is 2.4 kbps (80 ticks), 1 is 4.8 kbps (40), 2 is 9.6 kbps (20), 3 is 19.2 kbps (10), 4 is 28 kbps (8), 5 is 38.4 kbps (5), 6 is 56 kbps (4) and 7 is 64 kbps (3). Bit 0 of the code corresponds to the first rate switch.
- R4: When the latched doubling bit is 1, every delay in R3 is multiplied by two.
- R5: While the enabling condition holds, the block counts the ticks it samples. `cts_o` rises on the edge that samples the N-th such tick, where N is the delay. Ticks sampled while the condition is false are not counted. With circuit assurance off, the enabling condition is `rts_i` high.
- R6: When the enabling condition is sampled false, `cts_o` is 0 after that edge. The next delay is then counted again from zero.
- R7: With force-on latched and circuit assurance off, `cts_o` is 1 from the second edge after the capture onward, whatever the state of `rts_i`.
- R8: With circuit assurance latched and force-on off, the enabling condition is `rts_i` and `dcd_i` both high. When `dcd_i` is sampled low, `cts_o` is 0 after that edge.
- R9: With both force-on and circuit assurance latched, `cts_o` follows `dcd_i` one cycle later and ignores `rts_i`.
- R10: Changing the configuration pins without a reload request changes neither the latched outputs nor the delay that is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_req_i | input | 1 | Request to re-sample the configuration (one-cycle pulse) |
| tick_i | input | 1 | 0.1 ms timing strobe, one cycle wide |
| rts_i | input | 1 | Request to send from the terminal |
| dcd_i | input | 1 | Receive line signal detector |
| rate_sel_i | input | 3 | Rate code pins |
| dly_x2_i | input | 1 | Delay doubling pin |
| cts_force_i | input | 1 | Force clear-to-send on |
| ca_en_i | input | 1 | Circuit assurance enable |
| cts_o | output | 1 | Clear to send |
| cfg_valid_o | output | 1 | Configuration has been latched |
| cfg_rate_o | output | 3 | Latched rate code |
| cfg_x2_o | output | 1 | Latched doubling bit |
| cfg_force_o | output | 1 | Latched force-on bit |
| cfg_ca_o | output | 1 | Latched circuit-assurance bit |

## Verification
The bench builds the block with its default `DLY_SCALE` of 1, so one tick strobe is one delay unit. The longest turnaround, 160 ticks at the slowest rate with doubling, therefore takes a few hundred cycles. Because of this, every entry of the rate table can be measured exactly to the tick, both plain and doubled. The bench also walks through the gating combinations of force-on and circuit assurance, a dropped request in the middle of a count, and configuration pins that change without a reload.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef struct packed {
    logic [2:0] rate;
    logic       x2;
    logic       force_on;
    logic       ca_en;
  } cts_cfg_t;

  // Base turnaround in 0.1 ms units, indexed by the rate code
  function automatic int unsigned base_ticks(input logic [2:0] code);
    case (code)
      3'd0:    base_ticks = 80;
      3'd1:    base_ticks = 40;
      3'd2:    base_ticks = 20;
      3'd3:    base_ticks = 10;
      3'd4:    base_ticks = 8;
      3'd5:    base_ticks = 5;
      3'd6:    base_ticks = 4;
      default: base_ticks = 3;
    endcase
  endfunction

  function automatic int unsigned delay_ticks(input logic [2:0] code,
                                              input logic x2,
                                              input int unsigned scale);
    int unsigned t;
    t = base_ticks(code) * scale;
    delay_ticks = x2 ? (t << 1) : t;
  endfunction

endpackage

// File: rtl/cts_cfg_latch.sv
module cts_cfg_latch
  import cts_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     reload_i,
  input  cts_cfg_t cfg_i,
  output cts_cfg_t cfg_o,
  output logic     valid_o,
  output logic     load_o
);

  cts_cfg_t cfg_q;
  logic     valid_q;

  assign load_o  = !valid_q || reload_i;
  assign cfg_o   = cfg_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_o) begin
      cfg_q   <= cfg_i;
      valid_q <= 1'b1;
    end
  end

  // R10: latched word only moves on a capture event
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !reload_i) |=> $stable(cfg_q));

  // R1: once captured, the word stays valid
  p_valid_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);

endmodule

// File: rtl/cts_delay_timer.sv
module cts_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             exp_q;
  logic             hit;

  assign cnt_inc   = cnt_q + 1'b1;
  assign hit       = (cnt_inc >= limit_i);
  assign expired_o = exp_q;
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clear_i || !run_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_i && !exp_q) begin
      cnt_q <= cnt_inc;
      if (hit) exp_q <= 1'b1;
    end
  end

  // R5: count never passes the programmed delay
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= limit_i);

  // R5: expiry only follows a sampled tick
  p_expire_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_o) |-> $past(tick_i));

  // R6: losing the condition clears the count
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (count_o == '0 && !expired_o));

endmodule

// File: rtl/cts_out_stage.sv
module cts_out_stage
  import cts_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hold_i,
  input  logic     valid_i,
  input  cts_cfg_t cfg_i,
  input  logic     rts_i,
  input  logic     dcd_i,
  input  logic     expired_i,
  output logic     run_o,
  output logic     cts_o
);

  logic carrier_ok;
  logic forced_q;

  assign carrier_ok = !cfg_i.ca_en || dcd_i;
  assign run_o      = valid_i && !cfg_i.force_on && rts_i && carrier_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) forced_q <= 1'b0;
    else         forced_q <= !hold_i && cfg_i.force_on && carrier_ok;
  end

  assign cts_o = forced_q || expired_i;

  // R8: carrier loss under circuit assurance removes CTS
  p_ca_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.ca_en && !dcd_i) |=> !cts_o);

  // R6: request drop removes CTS when not forced
  p_rts_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cfg_i.force_on && !rts_i) |=> !cts_o);

endmodule

// File: rtl/cts_handshake_ctrl.sv
module cts_handshake_ctrl
  import cts_pkg::*;
#(
  parameter int unsigned DLY_SCALE = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reload_req_i,
  input  logic       tick_i,
  input  logic       rts_i,
  input  logic       dcd_i,
  input  logic [2:0] rate_sel_i,
  input  logic       dly_x2_i,
  input  logic       cts_force_i,
  input  logic       ca_en_i,
  output logic       cts_o,
  output logic       cfg_valid_o,
  output logic [2:0] cfg_rate_o,
  output logic       cfg_x2_o,
  output logic       cfg_force_o,
  output logic       cfg_ca_o
);

  localparam int unsigned MAX_TICKS = 160 * DLY_SCALE;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  cts_cfg_t         cfg_pins;
  cts_cfg_t         cfg_q;
  logic             cfg_valid;
  logic             cfg_load;
  logic             hold_off;
  logic             run;
  logic             expired;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;

  assign cfg_pins = '{rate: rate_sel_i, x2: dly_x2_i,
                      force_on: cts_force_i, ca_en: ca_en_i};
  assign hold_off = cfg_load;
  assign limit    = CNT_W'(delay_ticks(cfg_q.rate, cfg_q.x2, DLY_SCALE));

  cts_cfg_latch u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload_req_i),
    .cfg_i   (cfg_pins),
    .cfg_o   (cfg_q),
    .valid_o (cfg_valid),
    .load_o  (cfg_load)
  );

  cts_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (hold_off),
    .run_i    (run),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .expired_o(expired),
    .count_o  (count)
  );

  cts_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold_off),
    .valid_i  (cfg_valid),
    .cfg_i    (cfg_q),
    .rts_i    (rts_i),
    .dcd_i    (dcd_i),
    .expired_i(expired),
    .run_o    (run),
    .cts_o    (cts_o)
  );

  assign cfg_valid_o = cfg_valid;
  assign cfg_rate_o  = cfg_q.rate;
  assign cfg_x2_o    = cfg_q.x2;
  assign cfg_force_o = cfg_q.force_on;
  assign cfg_ca_o    = cfg_q.ca_en;

  // R2: no CTS before the configuration is latched
  p_off_unlatched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_o |-> !cts_o);

  // R2: a reload request drops CTS for a cycle
  p_reload_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_i |=> !cts_o);

  // R7: forced CTS without circuit assurance
  p_force_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_o && !reload_req_i && cfg_force_o && !cfg_ca_o) |=> cts_o);

  // R9: forced CTS follows the carrier detect under circuit assurance
  p_force_ca_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_o && !reload_req_i && cfg_force_o && cfg_ca_o && dcd_i) |=> cts_o);

endmodule

// File: tb/cts_handshake_ctrl_tb.sv
module cts_handshake_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reload = 1'b0;
  logic       tick = 1'b0;
  logic       rts = 1'b0;
  logic       dcd = 1'b0;
  logic [2:0] rate = 3'd0;
  logic       x2 = 1'b0;
  logic       frc = 1'b0;
  logic       ca = 1'b0;
  logic       cts, vld, c_x2, c_frc, c_ca;
  logic [2:0] c_rate;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cts_handshake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reload_req_i(reload), .tick_i(tick),
    .rts_i(rts), .dcd_i(dcd), .rate_sel_i(rate), .dly_x2_i(x2),
    .cts_force_i(frc), .ca_en_i(ca), .cts_o(cts), .cfg_valid_o(vld),
    .cfg_rate_o(c_rate), .cfg_x2_o(c_x2), .cfg_force_o(c_frc), .cfg_ca_o(c_ca)
  );

  // turnaround per rate in microseconds; one tick is 100 us
  function automatic int exp_ticks(input int code, input bit dbl);
    int us [8] = '{8000, 4000, 2000, 1000, 800, 500, 400, 300};
    exp_ticks = (us[code] / 100) * (dbl ? 2 : 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
    end
    tick = 1'b0;
  endtask

  task automatic do_reload(input logic [2:0] r, input bit d, input bit f, input bit c);
    rate = r; x2 = d; frc = f; ca = c;
    reload = 1'b1;
    step();
    reload = 1'b0;
    check("R2 reload cycle cts", cts, 0);
    check("R1 latched word", {c_rate, c_x2, c_frc, c_ca}, {r, d, f, c});
  endtask

  task automatic measure(input string req, input int n);
    rts = 1'b1;
    ticks(n - 1);
    check({req, " cts before last tick"}, cts, 0);
    ticks(1);
    check({req, " cts on last tick"}, cts, 1);
  endtask

  task automatic t_reset();
    rate = 3'd5; x2 = 1'b1; frc = 1'b1; ca = 1'b0; rts = 1'b1;
    step();
    check("R2 cts in reset", cts, 0);
    check("R2 valid in reset", vld, 0);
    rst_n = 1'b1;
    step();
    check("R1 valid after first edge", vld, 1);
    check("R1 captured word", {c_rate, c_x2, c_frc, c_ca}, {3'd5, 1'b1, 1'b1, 1'b0});
    rts = 1'b0;
  endtask

  task automatic t_rates();
    for (int c = 0; c < 8; c++) begin
      rts = 1'b0;
      do_reload(3'(c), 1'b0, 1'b0, 1'b0);
      measure("R3 R5 rate table", exp_ticks(c, 1'b0));
    end
    rts = 1'b0;
  endtask

  task automatic t_double();
    do_reload(3'd0, 1'b1, 1'b0, 1'b0);
    measure("R4 doubled slowest", exp_ticks(0, 1'b1));
    rts = 1'b0;
    do_reload(3'd7, 1'b1, 1'b0, 1'b0);
    measure("R4 doubled fastest", exp_ticks(7, 1'b1));
    rts = 1'b0;
  endtask

  task automatic t_drop();
    do_reload(3'd7, 1'b0, 1'b0, 1'b0);
    measure("R5 base", 3);
    rts = 1'b0;
    step();
    check("R6 cts drop", cts, 0);
    ticks(5);
    check("R5 ticks ignored while idle", cts, 0);
    rts = 1'b1;
    ticks(2);
    check("R6 restart from zero", cts, 0);
    rts = 1'b0;
    step();
    rts = 1'b1;
    ticks(2);
    check("R6 abort mid count restarts", cts, 0);
    ticks(1);
    check("R6 completes after restart", cts, 1);
    rts = 1'b0;
    step();
  endtask

  task automatic t_force();
    do_reload(3'd0, 1'b0, 1'b1, 1'b0);
    step();
    check("R7 forced cts rts low", cts, 1);
    rts = 1'b1;
    step();
    rts = 1'b0;
    step();
    check("R7 forced cts after rts toggle", cts, 1);
  endtask

  task automatic t_assure();
    dcd = 1'b0;
    do_reload(3'd7, 1'b0, 1'b0, 1'b1);
    rts = 1'b1;
    ticks(5);
    check("R8 no cts without carrier", cts, 0);
    dcd = 1'b1;
    ticks(2);
    check("R8 count starts with carrier", cts, 0);
    ticks(1);
    check("R8 cts with both on", cts, 1);
    dcd = 1'b0;
    step();
    check("R8 carrier loss drops cts", cts, 0);
    rts = 1'b0;
  endtask

  task automatic t_force_assure();
    dcd = 1'b0;
    do_reload(3'd3, 1'b0, 1'b1, 1'b1);
    step();
    check("R9 forced but no carrier", cts, 0);
    dcd = 1'b1;
    rts = 1'b0;
    step();
    check("R9 forced follows carrier", cts, 1);
    dcd = 1'b0;
    step();
    check("R9 forced drops with carrier", cts, 0);
  endtask

  task automatic t_pins_ignored();
    do_reload(3'd7, 1'b0, 1'b0, 1'b0);
    rate = 3'd0; x2 = 1'b1; frc = 1'b1; ca = 1'b1; dcd = 1'b0;
    step();
    check("R10 latched word kept", {c_rate, c_x2, c_frc, c_ca}, {3'd7, 1'b0, 1'b0, 1'b0});
    check("R10 force pin ignored", cts, 0);
    measure("R10 delay unchanged", 3);
    rts = 1'b0;
    step();
  endtask

  initial begin
    t_reset();
    t_rates();
    t_double();
    t_drop();
    t_force();
    t_assure();
    t_force_assure();
    t_pins_ignored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule